// File: doc/BRIEF.md
# Iterative Integer Divider with Remainder Reuse

This block divides two integers for a 64-bit integer datapath. It returns either the quotient or the remainder. The operands are treated as signed or unsigned, and the block works either at full width or on the low halves of the operands (word mode). A request carries a 2-bit operation code, a word-mode flag and two operands. It is taken on a valid/ready handshake. The answer comes back with a single-cycle done pulse.

A normal division runs a shift-subtract loop on the operand magnitudes and produces one quotient bit per clock. One clock before the loop prepares it, and one clock after it applies the signs. Two cases skip the loop and finish in two cycles with fixed answers: a zero divisor, and the most negative signed value divided by minus one. The unit keeps the operands, signedness, width and both results of the last completed division. A following request with the same operands, signedness and width (for example a remainder that follows its quotient) is answered from that store in one cycle. Because the store is matched on operand values, a reused answer is always correct, whatever happened to the source registers in between.

Top module: `intdiv_unit`

## Requirements
- R1: A request is taken on a rising edge where in_valid and in_ready are both high. For a request that is not answered from the store, in_ready is low from the next cycle until the done cycle. out_done is high for one cycle per request, and it stays high for a second cycle only when a stored-answer request is taken during that done cycle.
- R2: Operation code: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder (bit 0 selects unsigned, bit 1 selects remainder). Unsigned results satisfy a = q*b + r with r < b.
- R3: A signed quotient is truncated toward zero. A nonzero signed remainder has the sign of the dividend.
- R4: With a zero divisor at full width, the quotient is all ones and the remainder equals the dividend, for both signed and unsigned codes.
- R5: A signed full-width division of 0x8000000000000000 by all ones gives quotient 0x8000000000000000 and remainder 0.
- R6: With in_word high, only bits 31:0 of each operand are used. The 32-bit result is sign-extended to 64 bits, for signed and unsigned codes alike.
- R7: In word mode a zero low divisor gives a quotient of all 64 ones and a remainder equal to the sign-extended low dividend. A signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0xFFFFFFFF80000000 and remainder 0.
- R8: A normal division raises out_done after rising edge N+3, where the taking edge counts as the first (N = 64 at full width, 32 in word mode).
- R9: A zero-divisor or overflow request raises out_done after the second edge.
- R10: A request whose operands, unsigned bit and word flag all match the last completed request raises out_done after the first edge, with the correct quotient or remainder. A mismatch in any of these takes the normal or special latency.
- R11: Reset abandons a division in progress: no done pulse follows, in_ready is high after reset, and the stored answers are invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 2 | Operation code (R2) |
| in_word | input | 1 | Word-mode select |
| in_a | input | 64 | Dividend |
| in_b | input | 64 | Divisor |
| out_done | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Quotient or remainder, valid with out_done |

## Verification
A wrong iteration count or a bit lost from the remainder register shows up in the first normal division: the value is wrong and the done pulse arrives at the wrong edge. Both are seen in the same result cycle. A bad sign fixup is visible only when the operand signs differ, so mixed-sign and negative-dividend cases are driven explicitly. A stale or over-eager answer store shows up as a one-cycle latency where a full run was expected, or as the other result of a pair coming back. The bench therefore checks the latency of every request against its own record of the last operands.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

   typedef enum logic [1:0] {
      OP_DIV  = 2'b00,
      OP_DIVU = 2'b01,
      OP_REM  = 2'b10,
      OP_REMU = 2'b11
   } div_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ITER,
      ST_FIX,
      ST_SPEC
   } div_state_e;

   typedef struct packed {
      logic neg_q;
      logic neg_r;
      logic div0;
      logic ovf;
   } div_flags_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
   import intdiv_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit HAS_WORD = 1'b1
) (
   input  logic            uns,
   input  logic            word,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] mag_a,
   output logic [XLEN-1:0] mag_b,
   output logic [XLEN-1:0] dvd_res,
   output div_flags_t      flags
);
   localparam int HW = XLEN / 2;

   logic [XLEN-1:0] ext_a, ext_b;
   logic            sa, sb, zero_b, min_a, m1_b;

   generate
      if (HAS_WORD) begin : g_word
         always_comb begin
            if (word) begin
               ext_a   = uns ? {{HW{1'b0}}, a[HW-1:0]} : {{HW{a[HW-1]}}, a[HW-1:0]};
               ext_b   = uns ? {{HW{1'b0}}, b[HW-1:0]} : {{HW{b[HW-1]}}, b[HW-1:0]};
               dvd_res = {{HW{a[HW-1]}}, a[HW-1:0]};
               sa      = !uns && a[HW-1];
               sb      = !uns && b[HW-1];
               zero_b  = (b[HW-1:0] == '0);
               min_a   = (a[HW-1:0] == {1'b1, {(HW-1){1'b0}}});
               m1_b    = (b[HW-1:0] == '1);
            end else begin
               ext_a   = a;
               ext_b   = b;
               dvd_res = a;
               sa      = !uns && a[XLEN-1];
               sb      = !uns && b[XLEN-1];
               zero_b  = (b == '0);
               min_a   = (a == {1'b1, {(XLEN-1){1'b0}}});
               m1_b    = (b == '1);
            end
         end
      end else begin : g_full
         logic unused_word;
         assign unused_word = word;
         always_comb begin
            ext_a   = a;
            ext_b   = b;
            dvd_res = a;
            sa      = !uns && a[XLEN-1];
            sb      = !uns && b[XLEN-1];
            zero_b  = (b == '0);
            min_a   = (a == {1'b1, {(XLEN-1){1'b0}}});
            m1_b    = (b == '1);
         end
      end
   endgenerate

   always_comb begin
      mag_a       = sa ? (~ext_a + 1'b1) : ext_a;
      mag_b       = sb ? (~ext_b + 1'b1) : ext_b;
      flags.neg_q = sa ^ sb;
      flags.neg_r = sa;
      flags.div0  = zero_b;
      flags.ovf   = !uns && !zero_b && min_a && m1_b;
   end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
   parameter int XLEN     = 64,
   parameter bit HAS_WORD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic            word,
   input  logic [XLEN-1:0] dvd,
   input  logic [XLEN-1:0] dvs,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   localparam int HW = XLEN / 2;

   logic [XLEN-1:0] dvs_r;
   logic [XLEN:0]   trial, diff;
   logic            ge;
   logic [XLEN-1:0] start_q;

   generate
      if (HAS_WORD) begin : g_word_load
         assign start_q = word ? {dvd[HW-1:0], {HW{1'b0}}} : dvd;
      end else begin : g_full_load
         logic unused_w;
         assign unused_w = word;
         assign start_q  = dvd;
      end
   endgenerate

   always_comb begin
      trial = {rem, quo[XLEN-1]};
      diff  = trial - {1'b0, dvs_r};
      ge    = !diff[XLEN];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         dvs_r <= '0;
      end else if (load) begin
         quo   <= start_q;
         rem   <= '0;
         dvs_r <= dvs;
      end else if (step) begin
         rem <= ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
         quo <= {quo[XLEN-2:0], ge};
      end
   end

   // partial remainder never reaches the divisor after a subtract step (R2)
   assert_rem_below_divisor_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && dvs_r != '0) |=> (rem < dvs_r));

endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix #(
   parameter int XLEN     = 64,
   parameter bit HAS_WORD = 1'b1
) (
   input  logic            word,
   input  logic            neg_q,
   input  logic            neg_r,
   input  logic [XLEN-1:0] quo,
   input  logic [XLEN-1:0] rem,
   output logic [XLEN-1:0] q_out,
   output logic [XLEN-1:0] r_out
);
   localparam int HW = XLEN / 2;

   logic [XLEN-1:0] q_s, r_s;

   always_comb begin
      q_s = neg_q ? (~quo + 1'b1) : quo;
      r_s = neg_r ? (~rem + 1'b1) : rem;
   end

   generate
      if (HAS_WORD) begin : g_word_ext
         assign q_out = word ? {{HW{q_s[HW-1]}}, q_s[HW-1:0]} : q_s;
         assign r_out = word ? {{HW{r_s[HW-1]}}, r_s[HW-1:0]} : r_s;
      end else begin : g_full_out
         logic unused_w;
         assign unused_w = word;
         assign q_out    = q_s;
         assign r_out    = r_s;
      end
   endgenerate

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
   import intdiv_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit HAS_WORD = 1'b1,
   parameter bit CACHE_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [1:0]      in_op,
   input  logic            in_word,
   input  logic [XLEN-1:0] in_a,
   input  logic [XLEN-1:0] in_b,
   output logic            out_done,
   output logic [XLEN-1:0] out_result
);
   localparam int HW = XLEN / 2;
   localparam int CW = $clog2(XLEN + 1);

   generate
      if (XLEN < 8 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("intdiv_unit: XLEN must be even and at least 8");
      end
   endgenerate

   div_state_e      state;
   logic [CW-1:0]   cnt;
   logic            acc, hit, word_eff;
   logic [XLEN-1:0] p_mag_a, p_mag_b, p_dvd_res;
   div_flags_t      p_flags;

   logic [XLEN-1:0] mag_a_r, mag_b_r, dvd_res_r;
   div_flags_t      flags_r;
   logic            rem_r, word_r;

   logic [XLEN-1:0] k_a, k_b;
   logic            k_uns, k_word;
   logic            c_valid, c_uns, c_word;
   logic [XLEN-1:0] c_a, c_b, c_q, c_r;

   logic [XLEN-1:0] core_q, core_r, fix_q, fix_r, sp_q, sp_r;
   logic            core_load, core_step;

   assign word_eff = HAS_WORD ? in_word : 1'b0;
   assign in_ready = (state == ST_IDLE);
   assign acc      = in_valid && in_ready;

   generate
      if (CACHE_EN) begin : g_cache_hit
         assign hit = c_valid && (c_a == in_a) && (c_b == in_b) &&
                      (c_uns == in_op[0]) && (c_word == word_eff);
      end else begin : g_no_cache
         assign hit = 1'b0;
      end
   endgenerate

   intdiv_prep #(.XLEN(XLEN), .HAS_WORD(HAS_WORD)) prep_i (
      .uns     (in_op[0]),
      .word    (word_eff),
      .a       (in_a),
      .b       (in_b),
      .mag_a   (p_mag_a),
      .mag_b   (p_mag_b),
      .dvd_res (p_dvd_res),
      .flags   (p_flags)
   );

   assign core_load = (state == ST_SETUP);
   assign core_step = (state == ST_ITER);

   intdiv_core #(.XLEN(XLEN), .HAS_WORD(HAS_WORD)) core_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (core_load),
      .step  (core_step),
      .word  (word_r),
      .dvd   (mag_a_r),
      .dvs   (mag_b_r),
      .quo   (core_q),
      .rem   (core_r)
   );

   intdiv_fix #(.XLEN(XLEN), .HAS_WORD(HAS_WORD)) fix_i (
      .word  (word_r),
      .neg_q (flags_r.neg_q),
      .neg_r (flags_r.neg_r),
      .quo   (core_q),
      .rem   (core_r),
      .q_out (fix_q),
      .r_out (fix_r)
   );

   always_comb begin
      sp_q = flags_r.div0 ? {XLEN{1'b1}} : dvd_res_r;
      sp_r = flags_r.div0 ? dvd_res_r    : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         out_done   <= 1'b0;
         out_result <= '0;
         mag_a_r    <= '0;
         mag_b_r    <= '0;
         dvd_res_r  <= '0;
         flags_r    <= '0;
         rem_r      <= 1'b0;
         word_r     <= 1'b0;
         k_a        <= '0;
         k_b        <= '0;
         k_uns      <= 1'b0;
         k_word     <= 1'b0;
         c_valid    <= 1'b0;
         c_a        <= '0;
         c_b        <= '0;
         c_uns      <= 1'b0;
         c_word     <= 1'b0;
         c_q        <= '0;
         c_r        <= '0;
      end else begin
         out_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (acc) begin
                  mag_a_r   <= p_mag_a;
                  mag_b_r   <= p_mag_b;
                  dvd_res_r <= p_dvd_res;
                  flags_r   <= p_flags;
                  rem_r     <= in_op[1];
                  word_r    <= word_eff;
                  k_a       <= in_a;
                  k_b       <= in_b;
                  k_uns     <= in_op[0];
                  k_word    <= word_eff;
                  if (hit) begin
                     out_done   <= 1'b1;
                     out_result <= in_op[1] ? c_r : c_q;
                  end else if (p_flags.div0 || p_flags.ovf) begin
                     state <= ST_SPEC;
                  end else begin
                     state <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               cnt   <= word_r ? CW'(HW) : CW'(XLEN);
               state <= ST_ITER;
            end
            ST_ITER: begin
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) state <= ST_FIX;
            end
            ST_FIX: begin
               out_done   <= 1'b1;
               out_result <= rem_r ? fix_r : fix_q;
               c_valid    <= 1'b1;
               c_a        <= k_a;
               c_b        <= k_b;
               c_uns      <= k_uns;
               c_word     <= k_word;
               c_q        <= fix_q;
               c_r        <= fix_r;
               state      <= ST_IDLE;
            end
            ST_SPEC: begin
               out_done   <= 1'b1;
               out_result <= rem_r ? sp_r : sp_q;
               c_valid    <= 1'b1;
               c_a        <= k_a;
               c_b        <= k_b;
               c_uns      <= k_uns;
               c_word     <= k_word;
               c_q        <= sp_q;
               c_r        <= sp_r;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // a request that misses the store blocks further requests (R1)
   assert_busy_after_accept_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !hit) |=> !in_ready);

   // done lasts one cycle unless a new request was taken in that cycle (R1)
   assert_done_single_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && !acc) |=> !out_done);

   // the iteration counter is live whenever a step is applied (R8)
   assert_step_count_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      core_step |-> (cnt != '0));

   // word-mode results leave the port sign-extended (R6)
   assert_word_sext_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && word_r) |-> (out_result[XLEN-1:HW] == {HW{out_result[HW-1]}}));

   // a zero divisor never yields anything but an all-ones quotient (R4)
   assert_div0_quotient_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && flags_r.div0 && !rem_r) |-> (out_result == {XLEN{1'b1}}));

endmodule

// File: tb/intdiv_unit_tb.sv
`timescale 1ns/1ps
module intdiv_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = 2'b00;
   logic        in_word = 1'b0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_done;
   logic [63:0] out_result;

   int n_run = 0;
   int n_fail = 0;

   logic        lv = 1'b0;
   logic [63:0] la = '0, lb = '0;
   logic        luns = 1'b0, lw = 1'b0;

   always #10 clk = ~clk;

   intdiv_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_op      (in_op),
      .in_word    (in_word),
      .in_a       (in_a),
      .in_b       (in_b),
      .out_done   (out_done),
      .out_result (out_result)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic is_special(input logic [1:0] op, input logic w,
                                       input logic [63:0] a, input logic [63:0] b);
      if (w) return (b[31:0] == 0) || (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF);
      return (b == 0) || (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1);
   endfunction

   function automatic logic [63:0] ref_res(input logic [1:0] op, input logic w,
                                           input logic [63:0] a, input logic [63:0] b);
      logic [63:0] q, r;
      logic [31:0] q32, r32;
      if (w) begin
         if (b[31:0] == 0) begin
            q = '1; r = {{32{a[31]}}, a[31:0]};
         end else if (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF) begin
            q = {{32{a[31]}}, a[31:0]}; r = '0;
         end else begin
            if (op[0]) begin
               q32 = a[31:0] / b[31:0]; r32 = a[31:0] % b[31:0];
            end else begin
               q32 = $signed(a[31:0]) / $signed(b[31:0]);
               r32 = $signed(a[31:0]) % $signed(b[31:0]);
            end
            q = {{32{q32[31]}}, q32}; r = {{32{r32[31]}}, r32};
         end
      end else begin
         if (b == 0) begin
            q = '1; r = a;
         end else if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) begin
            q = a; r = '0;
         end else if (op[0]) begin
            q = a / b; r = a % b;
         end else begin
            q = $signed(a) / $signed(b); r = $signed(a) % $signed(b);
         end
      end
      return op[1] ? r : q;
   endfunction

   task automatic run_op(input string req, input logic [1:0] op, input logic w,
                         input logic [63:0] a, input logic [63:0] b);
      int lat, exp_lat;
      logic hitm;
      hitm = lv && la == a && lb == b && luns == op[0] && lw == w;
      exp_lat = hitm ? 1 : (is_special(op, w, a, b) ? 2 : (w ? 35 : 67));
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_op = op; in_word = w; in_a = a; in_b = b; in_valid = 1'b1;
      @(posedge clk);
      lat = 1;
      #2 in_valid = 1'b0;
      #3;
      while (!out_done && lat < 200) begin
         @(posedge clk);
         lat++;
         #5;
      end
      check({req, " result"}, out_result, ref_res(op, w, a, b));
      check({req, " latency"}, 64'(lat), 64'(exp_lat));
      lv = 1'b1; la = a; lb = b; luns = op[0]; lw = w;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      lv = 1'b0;
   endtask

   task automatic t_reset_state();
      #5;
      check("R1 in_ready after reset", 64'(in_ready), 64'd1);
      check("R1 out_done after reset", 64'(out_done), 64'd0);
   endtask

   task automatic t_unsigned();
      run_op("R2 divu", 2'b01, 1'b0, 64'd1000, 64'd7);
      run_op("R2 remu", 2'b11, 1'b0, 64'd1000, 64'd7);
      run_op("R2 divu big", 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);
      run_op("R2 remu small dividend", 2'b11, 1'b0, 64'd5, 64'hF000_0000_0000_0000);
   endtask

   task automatic t_signed();
      run_op("R3 div neg/pos", 2'b00, 1'b0, -64'sd17, 64'sd5);
      run_op("R3 rem neg/pos", 2'b10, 1'b0, -64'sd17, 64'sd5);
      run_op("R3 rem pos/neg", 2'b10, 1'b0, 64'sd17, -64'sd5);
      run_op("R3 div neg/neg", 2'b00, 1'b0, -64'sd100, -64'sd7);
      run_op("R3 div min/2", 2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'sd2);
   endtask

   task automatic t_div0();
      run_op("R4 div by zero signed", 2'b00, 1'b0, -64'sd9, 64'd0);
      run_op("R4 rem by zero signed", 2'b10, 1'b0, -64'sd9, 64'd0);
      run_op("R4 divu by zero", 2'b01, 1'b0, 64'd77, 64'd0);
      run_op("R9 remu by zero", 2'b11, 1'b1, 64'd12, 64'd0);
   endtask

   task automatic t_ovf();
      run_op("R5 overflow quotient", 2'b00, 1'b0, 64'h8000_0000_0000_0000, '1);
      run_op("R5 overflow remainder", 2'b10, 1'b0, 64'h8000_0000_0000_0000, '1);
      run_op("R5 unsigned same operands", 2'b01, 1'b0, 64'h8000_0000_0000_0000, '1);
   endtask

   task automatic t_word();
      run_op("R6 word divu upper ignored", 2'b01, 1'b1, 64'hDEAD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001);
      run_op("R6 word div signed", 2'b00, 1'b1, 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_0000_0003);
      run_op("R6 word remu", 2'b11, 1'b1, 64'h0000_0000_F000_0001, 64'h0000_0000_0000_0010);
      run_op("R7 word div by zero", 2'b00, 1'b1, 64'h1111_1111_8000_0005, 64'hFFFF_FFFF_0000_0000);
      run_op("R7 word rem by zero", 2'b10, 1'b1, 64'h1111_1111_8000_0006, 64'h0000_0001_0000_0000);
      run_op("R7 word overflow", 2'b00, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
   endtask

   task automatic t_reuse();
      run_op("R8 full div", 2'b00, 1'b0, 64'sd123456789, 64'sd1000);
      run_op("R10 paired rem", 2'b10, 1'b0, 64'sd123456789, 64'sd1000);
      run_op("R10 repeat quotient", 2'b00, 1'b0, 64'sd123456789, 64'sd1000);
      run_op("R10 signedness change", 2'b11, 1'b0, 64'sd123456789, 64'sd1000);
      run_op("R10 width change", 2'b11, 1'b1, 64'sd123456789, 64'sd1000);
   endtask

   task automatic t_abort();
      int seen;
      run_op("R11 warm store", 2'b01, 1'b0, 64'd999, 64'd10);
      @(negedge clk);
      in_op = 2'b00; in_word = 1'b0; in_a = 64'd5000; in_b = 64'd3; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (10) @(negedge clk);
      do_reset();
      seen = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (out_done) seen++;
      end
      check("R11 no done after abort", 64'(seen), 64'd0);
      check("R11 ready after abort", 64'(in_ready), 64'd1);
      run_op("R11 store invalidated", 2'b01, 1'b0, 64'd999, 64'd10);
   endtask

   initial begin
      fork
         begin
            do_reset();
            t_reset_state();
            t_unsigned();
            t_signed();
            t_div0();
            t_ovf();
            t_word();
            t_reuse();
            t_abort();
         end
         begin
            #(20 * 150000);
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule